// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block fills the 160-byte sprite attribute memory, which sits at FE00h-FE9Fh, with a copy of a source block. A write of a page number to the control port starts the copy. The source block begins at that page number times 100h. The engine then steps through 40 four-byte entries, one byte per clock. In each cycle it drives a source read address and a destination write address, and it forwards the read byte to the write port in the same cycle. The source memory answers combinationally.

A mode input sets which source pages are legal. In legacy mode only pages 80h to DFh start a copy. In extended mode any page from 00h to DFh starts a copy. A page outside the window is dropped. While a copy runs, `busy` is high, and the surrounding logic uses it to keep the processor off the buses. A legal write during a copy starts the copy again from the first byte, using the new page.

Top module: `oam_copy_engine`

## Requirements
- R1: After reset, `busy`, `src_rd_en` and `dst_wr_en` are low.
- R2: A write that is accepted makes `busy` high from the next cycle for exactly 160 consecutive cycles, after which it returns low.
- R3: While busy, `src_addr` equals {page, offset}, where page is the accepted page number in bits 15:8 and offset is bits 7:0. The offset starts at 00h and increases by one each cycle up to 9Fh.
- R4: While busy, `dst_addr` equals FE00h plus the same offset, and `dst_wr_data` equals `src_rd_data` in the same cycle. The destination therefore receives source byte i at location FE00h+i.
- R5: With `ext_mode` = 0 (legacy), pages 80h through DFh are accepted.
- R6: With `ext_mode` = 1 (extended), pages 00h through DFh are accepted.
- R7: A write whose page is outside the window for the current mode is ignored. `busy` stays low and no destination write occurs.
- R8: An accepted write while busy restarts the copy at offset 00h with the new page, and `busy` then lasts 160 cycles from that restart.
- R9: A write whose page is outside the window, arriving while busy, is ignored. The running copy continues with its old page and offset.
- R10: `src_rd_en` and `dst_wr_en` are high exactly when `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the source page register |
| cfg_page | input | 8 | Source page number (high address byte) |
| ext_mode | input | 1 | 0: legacy window 80h-DFh, 1: extended window 00h-DFh |
| busy | output | 1 | Copy in progress |
| src_rd_en | output | 1 | Source read enable |
| src_addr | output | 16 | Source read address |
| src_rd_data | input | 8 | Source read data, valid in the same cycle |
| dst_wr_en | output | 1 | Destination write enable |
| dst_addr | output | 16 | Destination write address (FE00h-FE9Fh) |
| dst_wr_data | output | 8 | Destination write data |

## Verification
An offset counter that skips a step, starts at the wrong value or stops in the wrong place shows up right away. The copied table then holds a byte from the wrong address, and the busy window is longer or shorter than 160 cycles. Both are visible once the transfer ends. A latched page that is wrong, or one that changes during a copy, shows on `src_addr` in the next cycle. It also spoils every byte that follows in the table. A window check that is wrong makes a page start a copy when it should be dropped, or the reverse. The sweep over all 256 pages in both modes catches this on the first page that crosses a window bound.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;
    localparam int ADDR_W = 16;
    localparam int PAGE_W = 8;
    localparam int LOW_W  = ADDR_W - PAGE_W;

    typedef struct packed {
        logic              busy;
        logic [PAGE_W-1:0] page;
    } oam_ctl_t;
endpackage

// File: rtl/oam_page_gate.sv
module oam_page_gate
    import oam_dma_pkg::*;
#(
    parameter logic [PAGE_W-1:0] LEGACY_LO = 8'h80,
    parameter logic [PAGE_W-1:0] EXT_LO    = 8'h00,
    parameter logic [PAGE_W-1:0] WIN_HI    = 8'hDF
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              ext_mode,
    output logic              page_ok
);
    logic [PAGE_W-1:0] lo_bound;

    always_comb begin
        lo_bound = ext_mode ? EXT_LO : LEGACY_LO;
        page_ok  = (page >= lo_bound) && (page <= WIN_HI);
    end
endmodule

// File: rtl/oam_offset_ctr.sv
module oam_offset_ctr #(
    parameter int XFER_LEN = 160,
    localparam int OFS_W   = $clog2(XFER_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [OFS_W-1:0] ofs,
    output logic             last
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(XFER_LEN - 1);

    logic [OFS_W-1:0] ofs_d, ofs_q;

    always_comb begin
        ofs_d = ofs_q;
        if (start) begin
            ofs_d = '0;
        end else if (run && ofs_q != LAST_OFS) begin
            ofs_d = ofs_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else begin
            ofs_q <= ofs_d;
        end
    end

    assign ofs  = ofs_q;
    assign last = (ofs_q == LAST_OFS);
endmodule

// File: rtl/oam_copy_engine.sv
module oam_copy_engine
    import oam_dma_pkg::*;
#(
    parameter int                XFER_LEN  = 160,
    parameter logic [PAGE_W-1:0] DST_PAGE  = 8'hFE,
    parameter logic [PAGE_W-1:0] LEGACY_LO = 8'h80,
    parameter logic [PAGE_W-1:0] EXT_LO    = 8'h00,
    parameter logic [PAGE_W-1:0] WIN_HI    = 8'hDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_page,
    input  logic              ext_mode,
    output logic              busy,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [7:0]        src_rd_data,
    output logic              dst_wr_en,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [7:0]        dst_wr_data
);
    localparam int OFS_W = $clog2(XFER_LEN);

    oam_ctl_t         ctl_d, ctl_q;
    logic             page_ok;
    logic             accept;
    logic [OFS_W-1:0] ofs;
    logic             ofs_last;
    logic [LOW_W-1:0] low_byte;

    oam_page_gate #(
        .LEGACY_LO (LEGACY_LO),
        .EXT_LO    (EXT_LO),
        .WIN_HI    (WIN_HI)
    ) gate_i (
        .page     (cfg_page),
        .ext_mode (ext_mode),
        .page_ok  (page_ok)
    );

    assign accept = cfg_wr && page_ok;

    oam_offset_ctr #(
        .XFER_LEN (XFER_LEN)
    ) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .run   (ctl_q.busy),
        .ofs   (ofs),
        .last  (ofs_last)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.busy = 1'b1;
            ctl_d.page = cfg_page;
        end else if (ctl_q.busy && ofs_last) begin
            ctl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign low_byte    = LOW_W'(ofs);
    assign busy        = ctl_q.busy;
    assign src_rd_en   = ctl_q.busy;
    assign dst_wr_en   = ctl_q.busy;
    assign src_addr    = {ctl_q.page, low_byte};
    assign dst_addr    = {DST_PAGE, low_byte};
    assign dst_wr_data = src_rd_data;
endmodule

// File: rtl/oam_copy_engine_chk.sv
module oam_copy_engine_chk
    import oam_dma_pkg::*;
#(
    parameter int                XFER_LEN  = 160,
    parameter logic [PAGE_W-1:0] DST_PAGE  = 8'hFE,
    parameter logic [PAGE_W-1:0] LEGACY_LO = 8'h80,
    parameter logic [PAGE_W-1:0] EXT_LO    = 8'h00,
    parameter logic [PAGE_W-1:0] WIN_HI    = 8'hDF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [7:0]        cfg_page,
    input logic              ext_mode,
    input logic              busy,
    input logic              src_rd_en,
    input logic [ADDR_W-1:0] src_addr,
    input logic [7:0]        src_rd_data,
    input logic              dst_wr_en,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [7:0]        dst_wr_data
);
    localparam logic [7:0] END_OFS = 8'(XFER_LEN - 1);

    logic legal;
    assign legal = ext_mode ? (cfg_page >= EXT_LO && cfg_page <= WIN_HI)
                            : (cfg_page >= LEGACY_LO && cfg_page <= WIN_HI);

    // R10
    enables_track_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_en == busy) && (dst_wr_en == busy));

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && legal) |=> busy);

    // R2
    end_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_addr[7:0] == END_OFS && !(cfg_wr && legal)) |=> !busy);

    // R7
    bad_page_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_wr && !legal) |=> !busy);

    // R3
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_addr[7:0] != END_OFS && !(cfg_wr && legal))
        |=> (busy && src_addr[7:0] == $past(src_addr[7:0]) + 8'd1));

    // R8
    restart_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && legal) |=> (src_addr[7:0] == 8'h00 && src_addr[15:8] == $past(cfg_page)));

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(cfg_wr && legal)) |=> (src_addr[15:8] == $past(src_addr[15:8])));

    // R4
    dest_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dst_addr[15:8] == DST_PAGE && dst_addr[7:0] == src_addr[7:0]
                  && dst_wr_data == src_rd_data));
endmodule

bind oam_copy_engine oam_copy_engine_chk #(
    .XFER_LEN  (XFER_LEN),
    .DST_PAGE  (DST_PAGE),
    .LEGACY_LO (LEGACY_LO),
    .EXT_LO    (EXT_LO),
    .WIN_HI    (WIN_HI)
) chk_i (.*);

// File: tb/oam_copy_engine_tb_top.sv
`timescale 1ns/1ps
module oam_copy_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_page = 8'h00;
    logic        ext_mode = 1'b0;
    logic        busy, src_rd_en, dst_wr_en;
    logic [15:0] src_addr, dst_addr;
    logic [7:0]  src_rd_data, dst_wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int addr_err = 0;
    logic [7:0] oam [160];

    always #2.5 clk = ~clk;

    oam_copy_engine dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_page    (cfg_page),
        .ext_mode    (ext_mode),
        .busy        (busy),
        .src_rd_en   (src_rd_en),
        .src_addr    (src_addr),
        .src_rd_data (src_rd_data),
        .dst_wr_en   (dst_wr_en),
        .dst_addr    (dst_addr),
        .dst_wr_data (dst_wr_data)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[15:8] ^ (a[7:0] * 8'd7) ^ 8'h5A;
    endfunction

    assign src_rd_data = src_byte(src_addr);

    always @(posedge clk) begin
        if (dst_wr_en) begin
            wr_cnt = wr_cnt + 1;
            if (dst_addr[15:8] != 8'hFE || dst_addr[7:0] >= 8'd160) begin
                addr_err = addr_err + 1;
            end else begin
                oam[dst_addr[7:0]] = dst_wr_data;
                if (src_addr[7:0] != dst_addr[7:0]) addr_err = addr_err + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit page_legal(input logic [7:0] p, input logic m);
        return m ? (p <= 8'hDF) : (p >= 8'h80 && p <= 8'hDF);
    endfunction

    task automatic clear_oam();
        for (int i = 0; i < 160; i++) oam[i] = 8'hxx;
        wr_cnt   = 0;
        addr_err = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_table(input logic [7:0] pg, input string req);
        int bad = 0;
        for (int i = 0; i < 160; i++) begin
            if (oam[i] !== src_byte({pg, 8'(i)})) bad++;
        end
        chk(bad == 0, req, bad, 0);
        chk(addr_err == 0, "R4", addr_err, 0);
    endtask

    task automatic run_copy(input logic [7:0] pg, input logic m);
        int  n;
        bit  ok = page_legal(pg, m);
        string rq = ok ? (m ? "R6" : "R5") : "R7";
        clear_oam();
        @(negedge clk);
        ext_mode = m; cfg_page = pg; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        count_busy(n);
        chk(n == (ok ? 160 : 0), ok ? "R2" : "R7", n, ok ? 160 : 0);
        chk(wr_cnt == (ok ? 160 : 0), rq, wr_cnt, ok ? 160 : 0);
        if (ok) check_table(pg, "R3");
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && src_rd_en == 0 && dst_wr_en == 0, "R1", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && dst_wr_en == 0, "R1", int'(busy), 0);

        // R5 R6 R7: sweep every page in both modes
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 256; p++) begin
                run_copy(8'(p), m[0]);
            end
        end

        // R8: legal restart mid-copy
        clear_oam();
        @(negedge clk);
        ext_mode = 1'b0; cfg_page = 8'h90; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (30) @(negedge clk);
        cfg_page = 8'hC3; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        count_busy(n);
        chk(n == 160, "R8", n, 160);
        check_table(8'hC3, "R8");

        // R9: illegal write mid-copy is ignored
        clear_oam();
        @(negedge clk);
        ext_mode = 1'b0; cfg_page = 8'h85; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (30) @(negedge clk);
        cfg_page = 8'h10; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        count_busy(n);
        chk(n == 129, "R9", n, 129);
        chk(wr_cnt == 160, "R9", wr_cnt, 160);
        check_table(8'h85, "R9");

        // R10: enables low once idle
        @(negedge clk);
        chk(src_rd_en == 0 && dst_wr_en == 0, "R10", int'(dst_wr_en), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule